// File: doc/BRIEF.md
# Dual-Channel ADC Readout Sequencer

This block reads conversion results out of an integrating ADC with two inputs and stores them in a word-addressed external memory of 32,768 words. The ADC pulls its active-low ready line low when a conversion pair is available. The sequencer then waits for a delay that software has programmed. After that it enables the converter's serial output and drives a data clock at one quarter of the system clock. It shifts in 40 bits: channel 1 first, then channel 2, each most significant bit first.

After the last bit the transmit enable goes high again. Each 20-bit result becomes a 24-bit word that carries a side tag. The word is written to memory as three single-cycle byte writes, and the word pointer then moves on. A mode input selects collection (0) or readback (1). Readouts start only in collection mode. Entering readback rewinds the pointer and clears the full condition. Once the word at the highest address has been written, the block marks itself full and ignores the ready line.

The ready input and the serial data input are assumed to be synchronous to the system clock.

Top module: `adc_readout_seq`

## Requirements
- R1: While reset is applied and just after it, `xmit_n` is 1, `dclk` is 0, `mem_we` is 0, `mem_addr` is 0 and `full` is 0.
- R2: A readout starts on the clock edge that sees `dvalid_n` at 0 after it was 1 on the edge before. This happens only while `mode_rb` is 0 and `full` is 0. `dly_cfg` and `side_in` are captured on that edge.
- R3: If the captured delay is D, `xmit_n` goes low on the (D+1)-th clock edge after the start edge.
- R4: While `xmit_n` is low, `dclk` makes exactly 40 pulses. Each pulse starts with 2 cycles low followed by 2 cycles high, so one pulse lasts 4 clocks. `dclk` is never high while `xmit_n` is high.
- R5: `sdata` is sampled on the clock edge where `dclk` rises. The first 20 bits are channel 1 and the next 20 bits are channel 2, each with the MSB first.
- R6: `xmit_n` returns high on the same edge where `dclk` falls after the 40th pulse. No memory write occurs while `xmit_n` is low.
- R7: Each stored word has the 20-bit result in bits 19..0 and the captured side tag in bit 22. Bits 20, 21 and 23 are 0.
- R8: Each word is written in three consecutive cycles with `mem_we`=1. `mem_lane` takes the values 0, 1, 2 and `mem_wdata` carries word bits 7..0, then 15..8, then 23..16. The channel 1 word is written first, then the channel 2 word.
- R9: `mem_addr` (15 bits by default) increases by 1 only after a lane-2 write. Both words of a readout are therefore written at consecutive addresses.
- R10: A falling `dvalid_n` while `mode_rb` is 1 starts nothing. `xmit_n` stays high and no write occurs.
- R11: After the word at the highest address is written, `full` becomes 1 and `mem_addr` stays at that address. The rest of that readout is dropped, and later falling edges of `dvalid_n` start nothing.
- R12: On the cycle after `mode_rb` rises, `full` is 0 and `mem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_rb | input | 1 | 0 = collect, 1 = readback (no readouts start) |
| dly_cfg | input | DLY_W | Delay in clocks from the ready edge to transmit enable |
| dvalid_n | input | 1 | Active-low data-ready from the ADC |
| side_in | input | 1 | Side tag stored in bit 22 of each word |
| sdata | input | 1 | Serial result data from the ADC |
| xmit_n | output | 1 | Active-low transmit enable to the ADC |
| dclk | output | 1 | Generated data clock, system clock / 4 |
| mem_we | output | 1 | Byte write strobe, one cycle per byte |
| mem_lane | output | 2 | Byte lane of the current write (0, 1, 2) |
| mem_wdata | output | 8 | Byte being written |
| mem_addr | output | ADDR_W | Word address pointer |
| full | output | 1 | The last word address has been written |

## Verification
Several rules are checked on every cycle: the data clock never runs while transmit is disabled, writes never overlap transmission, lanes appear in order, the pointer moves only after a lane-2 write or a readback entry, the unused tag bits stay zero, and nothing transmits while full. Other properties can only be shown by the bench's scenarios. These are the exact start latency for a given delay, the bit order and channel assignment of the shifted data, the byte content of each word, the 40-pulse count, and the dropped readouts in readback and full states. The bench shrinks the address width so that it can reach the full condition.

// File: rtl/adc_rd_pkg.sv
// Shared constants, state type and word packing for the ADC readout sequencer.
// Assumes a 20-bit result per channel and a 24-bit stored word.
package adc_rd_pkg;
    localparam int RES_W   = 20;
    localparam int WORD_W  = 24;
    localparam int TAG_POS = 22;
    localparam int NBYTES  = WORD_W / 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_STORE = 2'd3
    } rd_state_t;

    // Build the stored word: result in the low bits, tag at TAG_POS, rest zero.
    function automatic logic [WORD_W-1:0] pack_word(input logic [RES_W-1:0] res,
                                                    input logic tag);
        logic [WORD_W-1:0] w;
        w = '0;
        w[RES_W-1:0] = res;
        w[TAG_POS]   = tag;
        return w;
    endfunction
endpackage

// File: rtl/rd_fall_det.sv
// Detects a high-to-low transition on a synchronous active-low input.
// Assumes the input is already synchronous to clk; idles high after reset.
module rd_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic fall
);
    logic prev_q;

    // Remember the level from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sig_n;
    end

    assign fall = prev_q & ~sig_n;
endmodule

// File: rtl/rd_dclk_gen.sv
// Generates the serial data clock at clk/4 while enabled: two low phases,
// then two high phases. Gives a sample strobe on the edge where the clock
// rises and a last-phase strobe on the edge where it falls.
module rd_dclk_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic dclk,
    output logic sample,
    output logic last_ph
);
    logic [1:0] ph_q;
    logic       dclk_q;

    // Phase counter, held at zero when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) ph_q <= 2'd0;
        else               ph_q <= ph_q + 2'd1;
    end

    // Registered clock output, high during phases 2 and 3.
    always_ff @(posedge clk) begin
        if (!rst_n) dclk_q <= 1'b0;
        else        dclk_q <= en && (ph_q == 2'd1 || ph_q == 2'd2);
    end

    assign dclk    = dclk_q;
    assign sample  = en && (ph_q == 2'd1);
    assign last_ph = en && (ph_q == 2'd3);
endmodule

// File: rtl/rd_shift_in.sv
// Serial-in shift register, MSB first; holds both channel results.
// Assumes the caller strobes shift_en once per received bit.
module rd_shift_in #(
    parameter int LEN = 40
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] q
);
    logic [LEN-1:0] sr_q;

    // Shift the new bit into the least significant end.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr_q <= '0;
        else if (shift_en) sr_q <= {sr_q[LEN-2:0], din};
    end

    assign q = sr_q;
endmodule

// File: rtl/adc_readout_seq.sv
// Readout sequencer top: edge start, delay, serial capture of two channels,
// packing and three byte writes per word with a saturating word pointer.
// Assumes dvalid_n, sdata and mode_rb are synchronous to clk.
module adc_readout_seq
    import adc_rd_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DLY_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_rb,
    input  logic [DLY_W-1:0]  dly_cfg,
    input  logic              dvalid_n,
    input  logic              side_in,
    input  logic              sdata,
    output logic              xmit_n,
    output logic              dclk,
    output logic              mem_we,
    output logic [1:0]        mem_lane,
    output logic [7:0]        mem_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              full
);
    localparam int NBITS_I = 2 * RES_W;
    localparam int CNT_W   = $clog2(NBITS_I + 1);
    localparam logic [CNT_W-1:0]  NBITS    = CNT_W'(NBITS_I);
    localparam logic [ADDR_W-1:0] ADDR_MAX = '1;

    rd_state_t          state_q;
    logic [DLY_W-1:0]   dly_q;
    logic [CNT_W-1:0]   bit_q;
    logic               word_q;
    logic [1:0]         byte_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               full_q;
    logic               xmit_n_q;
    logic               side_q;
    logic               mode_q;
    logic               fall;
    logic               sample;
    logic               last_ph;
    logic [NBITS_I-1:0] sr;
    logic [WORD_W-1:0]  word;
    logic               start;
    logic               mode_rise;

    rd_fall_det i_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_n (dvalid_n),
        .fall  (fall)
    );

    rd_dclk_gen i_dclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (state_q == ST_SHIFT),
        .dclk    (dclk),
        .sample  (sample),
        .last_ph (last_ph)
    );

    rd_shift_in #(.LEN(NBITS_I)) i_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample),
        .din      (sdata),
        .q        (sr)
    );

    assign start     = (state_q == ST_IDLE) && fall && !mode_rb && !full_q;
    assign mode_rise = mode_rb && !mode_q;

    // Select the channel word being stored and pack it with the tag.
    assign word = pack_word(word_q ? sr[RES_W-1:0] : sr[NBITS_I-1:RES_W], side_q);

    // Sequencing: start, delay, shift, byte writes, pointer and full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            dly_q    <= '0;
            bit_q    <= '0;
            word_q   <= 1'b0;
            byte_q   <= 2'd0;
            addr_q   <= '0;
            full_q   <= 1'b0;
            xmit_n_q <= 1'b1;
            side_q   <= 1'b0;
            mode_q   <= 1'b0;
        end else begin
            mode_q <= mode_rb;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        dly_q   <= dly_cfg;
                        side_q  <= side_in;
                        state_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (dly_q == '0) begin
                        xmit_n_q <= 1'b0;
                        bit_q    <= '0;
                        state_q  <= ST_SHIFT;
                    end else begin
                        dly_q <= dly_q - 1'b1;
                    end
                end
                ST_SHIFT: begin
                    if (sample) bit_q <= bit_q + 1'b1;
                    if (last_ph && bit_q == NBITS) begin
                        xmit_n_q <= 1'b1;
                        word_q   <= 1'b0;
                        byte_q   <= 2'd0;
                        state_q  <= ST_STORE;
                    end
                end
                default: begin
                    if (byte_q == 2'(NBYTES - 1)) begin
                        byte_q <= 2'd0;
                        if (addr_q == ADDR_MAX) begin
                            full_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            addr_q <= addr_q + 1'b1;
                            if (word_q) state_q <= ST_IDLE;
                            word_q <= 1'b1;
                        end
                    end else begin
                        byte_q <= byte_q + 2'd1;
                    end
                end
            endcase
            if (mode_rise) begin
                addr_q <= '0;
                full_q <= 1'b0;
            end
        end
    end

    assign xmit_n    = xmit_n_q;
    assign mem_we    = (state_q == ST_STORE);
    assign mem_lane  = byte_q;
    assign mem_wdata = word[byte_q*8 +: 8];
    assign mem_addr  = addr_q;
    assign full      = full_q;
endmodule

// File: rtl/rd_seq_chk.sv
// Cycle-level properties of the readout sequencer, bound to its top.
module rd_seq_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mode_rb,
    input logic              xmit_n,
    input logic              dclk,
    input logic              mem_we,
    input logic [1:0]        mem_lane,
    input logic [7:0]        mem_wdata,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              full
);
    AST_DCLK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        dclk |-> !xmit_n); // R4
    AST_NO_WRITE_IN_XMIT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> xmit_n); // R6
    AST_LANE_ORDER_MID: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_lane == 2'd1) |-> $past(mem_we && mem_lane == 2'd0)); // R8
    AST_LANE_ORDER_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_lane == 2'd2) |-> $past(mem_we && mem_lane == 2'd1)); // R8
    AST_TAG_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && mem_lane == 2'd2) |-> (mem_wdata[7] == 1'b0 && mem_wdata[5:4] == 2'b00)); // R7
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr != $past(mem_addr)) |->
            (($past(mem_we) && $past(mem_lane) == 2'd2 && mem_addr == $past(mem_addr) + 1'b1)
             || ($past(mode_rb) && !$past(mode_rb, 2) && mem_addr == '0))); // R9
    AST_FULL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> xmit_n); // R11
    AST_READBACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_rb) && !$past(mode_rb, 2)) |-> (!full && mem_addr == '0)); // R12
endmodule

bind adc_readout_seq rd_seq_chk #(.ADDR_W(ADDR_W)) i_rd_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_rb   (mode_rb),
    .xmit_n    (xmit_n),
    .dclk      (dclk),
    .mem_we    (mem_we),
    .mem_lane  (mem_lane),
    .mem_wdata (mem_wdata),
    .mem_addr  (mem_addr),
    .full      (full)
);

// File: tb/test_adc_readout_seq.sv
// Bench: a behavioural ADC drives the serial data, and a queue of expected
// byte writes is compared against the memory port on every clock.
module test_adc_readout_seq;
    localparam int AW    = 3;
    localparam int DW    = 8;
    localparam int AMAX  = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_rb = 1'b0;
    logic [DW-1:0] dly_cfg = '0;
    logic          dvalid_n = 1'b1;
    logic          side_in = 1'b0;
    logic          sdata = 1'b0;
    logic          xmit_n, dclk, mem_we, full;
    logic [1:0]    mem_lane;
    logic [7:0]    mem_wdata;
    logic [AW-1:0] mem_addr;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int exp_addr = 0;
    bit exp_full = 0;
    int exp_q[$];   // entries: addr*1024 + lane*256 + byte

    always #4 clk = ~clk;

    adc_readout_seq #(.ADDR_W(AW), .DLY_W(DW)) i_adc_readout_seq (
        .clk(clk), .rst_n(rst_n), .mode_rb(mode_rb), .dly_cfg(dly_cfg),
        .dvalid_n(dvalid_n), .side_in(side_in), .sdata(sdata),
        .xmit_n(xmit_n), .dclk(dclk), .mem_we(mem_we), .mem_lane(mem_lane),
        .mem_wdata(mem_wdata), .mem_addr(mem_addr), .full(full)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of the write port with the expected queue.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (xmit_n && dclk) chk(0, "R4 dclk while xmit high", 1, 0);
            if (mem_we) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8/R10 unexpected write", {mem_addr, mem_lane, mem_wdata}, 0);
                end else begin
                    int e;
                    e = exp_q.pop_front();
                    chk(int'(mem_addr) * 1024 + int'(mem_lane) * 256 + int'(mem_wdata) == e,
                        "R7/R8/R9 write", int'(mem_addr) * 1024 + int'(mem_lane) * 256 + int'(mem_wdata), e);
                end
            end
        end
    end

    task automatic expect_word(input logic [19:0] res, input bit tag);
        logic [23:0] w;
        if (exp_full) return;
        w = {1'b0, tag, 2'b00, res};
        for (int b = 0; b < 3; b++) exp_q.push_back(exp_addr * 1024 + b * 256 + int'(w[b*8 +: 8]));
        if (exp_addr == AMAX) exp_full = 1;
        else exp_addr++;
    endtask

    task automatic readout(input int d, input logic [19:0] c1, input logic [19:0] c2, input bit tag);
        logic [39:0] bits;
        int gap;
        bits = {c1, c2};
        @(negedge clk);
        dly_cfg = DW'(d);
        side_in = tag;
        dvalid_n = 1'b0;
        expect_word(c1, tag);
        expect_word(c2, tag);
        for (int k = 0; k <= d; k++) begin
            @(negedge clk);
            chk(xmit_n == 1'b1, "R3 xmit early", xmit_n, 1);
        end
        @(negedge clk);
        chk(xmit_n == 1'b0, "R3 xmit low at D+1", xmit_n, 0);
        dvalid_n = 1'b1;
        side_in = ~tag;
        gap = 0;
        for (int i = 0; i < 40; i++) begin
            sdata = bits[39 - i];
            gap = 0;
            while (dclk !== 1'b1) begin @(negedge clk); gap++; end
            if (i > 0) chk(gap == 2, "R4 dclk period", gap + 2, 4);
            chk(xmit_n == 1'b0, "R4 xmit low during pulse", xmit_n, 0);
            @(negedge clk);
            chk(dclk == 1'b1, "R4 dclk high two cycles", dclk, 1);
            @(negedge clk);
            if (i < 39) chk(xmit_n == 1'b0, "R6 xmit held", xmit_n, 0);
        end
        chk(xmit_n == 1'b1 && dclk == 1'b0, "R6 xmit released", {xmit_n, dclk}, 2);
        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R8 all writes seen", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(xmit_n && !dclk && !mem_we && mem_addr == 0 && !full, "R1 reset state",
            {xmit_n, dclk, mem_we, full}, 8);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xmit_n && !dclk && !mem_we && mem_addr == 0 && !full, "R1 after reset",
            {xmit_n, dclk, mem_we, full}, 8);

        // R2 R5 R7: two patterns, different delays and tags
        readout(3, 20'hABCDE, 20'h12345, 1'b1);
        chk(mem_addr == 2, "R9 pointer after readout", mem_addr, 2);
        readout(0, 20'hFFFFF, 20'h00001, 1'b0);
        readout(7, 20'h80000, 20'h5A5A5, 1'b1);

        // R12: entering readback rewinds; R10: no start in readback
        @(negedge clk);
        mode_rb = 1'b1;
        @(negedge clk);
        chk(mem_addr == 0 && !full, "R12 rewind on readback", mem_addr, 0);
        dvalid_n = 1'b0;
        repeat (2) @(negedge clk);
        dvalid_n = 1'b1;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (k == 19) chk(xmit_n == 1'b1 && !mem_we, "R10 readback ignores edge", xmit_n, 1);
        end
        mode_rb = 1'b0;
        exp_addr = 0;
        exp_full = 0;
        repeat (2) @(negedge clk);

        // R11: fill all 2**AW words, then ignore edges
        for (int r = 0; r < 4; r++) readout(r, 20'h00F00 + 20'(r), 20'hF00F0 - 20'(r), r[0]);
        chk(full == 1'b1, "R11 full after last word", full, 1);
        chk(mem_addr == AW'(AMAX), "R11 pointer holds", mem_addr, AMAX);
        @(negedge clk);
        dvalid_n = 1'b0;
        repeat (2) @(negedge clk);
        dvalid_n = 1'b1;
        repeat (20) @(negedge clk);
        chk(xmit_n == 1'b1 && full == 1'b1, "R11 edge ignored while full", xmit_n, 1);

        // R11 drop of channel 2: start at last address
        mode_rb = 1'b1;
        @(negedge clk);
        mode_rb = 1'b0;
        @(negedge clk);
        chk(!full && mem_addr == 0, "R12 full cleared", full, 0);
        exp_addr = 0;
        exp_full = 0;
        for (int r = 0; r < 3; r++) readout(1, 20'h11111 * 20'(r + 1), 20'h22222, 1'b0);
        readout(2, 20'h3C3C3, 20'h77777, 1'b1);
        chk(full == 1'b1 && mem_addr == AW'(AMAX), "R11 full at max", full, 1);
        // Start at last address: shift pointer with odd count via readback + 7 words impossible; check hold
        chk(exp_q.size() == 0, "R8 queue drained", exp_q.size(), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule